// File: doc/BRIEF.md
# Horizontal Window Zoom and Expansion Resampler

This block enlarges one display window's line of pixels in the horizontal direction as the pixels stream out of memory. Source pixels arrive one at a time over a valid/ready handshake, and the first pixel of each line carries a line-start marker. The enlarged line leaves as a stream of registered pixels with a valid strobe. The first output pixel of each line carries its own line-start marker. Each instance handles one 8-bit colour component. Wider pixels use one instance per component, all given the same mode settings.

Two kinds of enlargement are chained. An integer zoom stage repeats each source pixel 1, 2 or 4 times. A fractional expansion stage then resamples the zoomed stream by 9/8 or by 3/2. For example, 640 pixels become 720 pixels at 9/8, or 960 pixels at 3/2. When smoothing is enabled and the final line width is at most 720 pixels, the expansion stage computes each output by linear interpolation between neighbouring pixels. Otherwise it picks the nearest neighbour.

Expansion takes effect when the window's own enable or the screen-wide enable is set. All mode inputs are static: they are changed only while the block is held in reset.

Top module: `hwin_hscaler`

## Requirements
- R1: While `rst` is high and on the cycle after it, `out_valid` is 0 and `in_ready` is 1.
- R2: With `zoom_mode` = 1, each source pixel is emitted twice in a row. After any accepted input, `in_ready` is 0 on the next cycle.
- R3: With `zoom_mode` = 2, each source pixel is emitted four times in a row. After an accepted input, `in_ready` stays 0 for the next three cycles.
- R4: With `zoom_mode` = 0 or 3 and no expansion in effect, the output line equals the source line, pixel for pixel.
- R5: With `exp_mode` = 1 (9/8), a zoomed line of Lz pixels gives ceil(Lz*9/8) outputs. Output k sits at source position i = floor(8k/9) with phase f = 8k mod 9. Its smoothed value is (a*(9-f) + b*f + 4)/9, where a is pixel i and b is pixel i+1.
- R6: With `exp_mode` = 2 (3/2), a zoomed line of Lz pixels gives ceil(Lz*3/2) outputs. Output k uses i = floor(2k/3) and f = 2k mod 3. Its smoothed value is (a*(3-f) + b*f + 1)/3.
- R7: When i is the last zoomed pixel of the line, b is taken equal to a. No pixel of the next line is mixed in.
- R8: When smoothing is off, or the final width exceeds 720, each output is b if 2f > N and a otherwise. N is 9 for the 9/8 ratio and 3 for the 3/2 ratio.
- R9: Expansion is in effect only when `win_exp_en` or `all_exp_en` is 1. `exp_mode` 0 or 3 means no expansion.
- R10: Zoom is applied before expansion, so the expansion sees each source pixel repeated.
- R11: The interpolation phase restarts at every line-start input. `out_sol` is 1 exactly on the first output of each line and only when `out_valid` is 1.
- R12: The final width is ceil(line_len * zoom * N / M), where M is 8 for 9/8 and 2 for 3/2. A width of exactly 720 is still smoothed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| zoom_mode | input | 2 | 0: x1, 1: x2, 2: x4, 3: x1 |
| exp_mode | input | 2 | 0: none, 1: 9/8, 2: 3/2, 3: none |
| win_exp_en | input | 1 | Window expansion enable |
| all_exp_en | input | 1 | Screen-wide expansion enable |
| smooth_en | input | 1 | Interpolating filter enable |
| line_len | input | LEN_W | Source pixels per line |
| in_valid | input | 1 | Source pixel valid |
| in_ready | output | 1 | Source pixel accepted when high with in_valid |
| in_data | input | DW | Source pixel component |
| in_sol | input | 1 | Marks first source pixel of a line |
| out_valid | output | 1 | Output pixel valid |
| out_data | output | DW | Output pixel component |
| out_sol | output | 1 | Marks first output pixel of a line |

## Verification
The bench targets the line end. A design that reads one pixel past the end would blend in the next line's first pixel or would hang waiting for it. The bench also runs two short 9/8 lines back to back, chosen so that the phase is nonzero when the first line ends. A design that does not restart the phase at the line-start marker would shift every sample of the second line. Widths of exactly 720 and of 960 probe the smoothing limit: an off-by-one comparison would filter the 960 line or stop filtering the 720 line. Reserved mode codes, expansion with both enables low, and the screen-wide enable alone are each run to catch wrong decoding or a swapped order of zoom and expansion.

// File: rtl/hzx_pkg.sv
package hzx_pkg;

  typedef struct packed {
    logic [3:0] num;     // outputs per group
    logic [3:0] den;     // inputs per group
    logic [1:0] den_sh;  // log2 of den
  } ratio_t;

  function automatic ratio_t ratio_of(input logic [1:0] code, input logic enable);
    ratio_t r;
    r.num    = 4'd1;
    r.den    = 4'd1;
    r.den_sh = 2'd0;
    if (enable) begin
      case (code)
        2'd1: begin r.num = 4'd9; r.den = 4'd8; r.den_sh = 2'd3; end
        2'd2: begin r.num = 4'd3; r.den = 4'd2; r.den_sh = 2'd1; end
        default: ;
      endcase
    end
    return r;
  endfunction

  function automatic logic [1:0] zoom_shift(input logic [1:0] code);
    case (code)
      2'd1:    return 2'd1;
      2'd2:    return 2'd2;
      default: return 2'd0;
    endcase
  endfunction

  function automatic logic [1:0] zoom_last_copy(input logic [1:0] code);
    case (code)
      2'd1:    return 2'd1;
      2'd2:    return 2'd3;
      default: return 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/hzx_mode.sv
module hzx_mode
  import hzx_pkg::*;
#(
  parameter int LEN_W        = 12,
  parameter int MAX_SMOOTH_W = 720
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       zoom_mode,
  input  logic [1:0]       exp_mode,
  input  logic             win_exp_en,
  input  logic             all_exp_en,
  input  logic             smooth_en,
  input  logic [LEN_W-1:0] line_len,
  output logic [1:0]       zoom_q,
  output logic [3:0]       num_q,
  output logic [3:0]       den_q,
  output logic             smooth_q
);
  localparam int WW = LEN_W + 7;

  ratio_t        r;
  logic [WW-1:0] zlen;
  logic [WW-1:0] prod;
  logic [WW-1:0] width;
  logic          fits;

  always_comb begin
    r     = ratio_of(exp_mode, win_exp_en | all_exp_en);
    zlen  = WW'(line_len) << zoom_shift(zoom_mode);
    prod  = zlen * WW'(r.num);
    width = (prod + WW'(r.den) - WW'(1)) >> r.den_sh;
    fits  = (width <= WW'(MAX_SMOOTH_W));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      zoom_q   <= 2'd0;
      num_q    <= 4'd1;
      den_q    <= 4'd1;
      smooth_q <= 1'b0;
    end else begin
      zoom_q   <= zoom_mode;
      num_q    <= r.num;
      den_q    <= r.den;
      smooth_q <= smooth_en & fits;
    end
  end
endmodule

// File: rtl/hzx_replicate.sv
module hzx_replicate
  import hzx_pkg::*;
#(
  parameter int DW    = 8,
  parameter int LEN_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       zoom,
  input  logic [LEN_W-1:0] line_len,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic [DW-1:0]    s_data,
  input  logic             s_sol,
  output logic             m_valid,
  input  logic             m_ready,
  output logic [DW-1:0]    m_data,
  output logic             m_sol,
  output logic             m_last
);
  logic [DW-1:0]    pix_q;
  logic             held_q;
  logic             sol_q;
  logic             last_q;
  logic [1:0]       rep_q;
  logic [LEN_W-1:0] cnt_q;
  logic [LEN_W-1:0] idx;
  logic             src_last;
  logic             final_copy;

  assign final_copy = (rep_q == zoom_last_copy(zoom));
  assign s_ready    = !held_q || (m_ready && final_copy);
  assign idx        = s_sol ? '0 : cnt_q;
  assign src_last   = (idx == line_len - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      pix_q  <= '0;
      held_q <= 1'b0;
      sol_q  <= 1'b0;
      last_q <= 1'b0;
      rep_q  <= 2'd0;
      cnt_q  <= '0;
    end else if (s_valid && s_ready) begin
      pix_q  <= s_data;
      held_q <= 1'b1;
      sol_q  <= s_sol;
      last_q <= src_last;
      rep_q  <= 2'd0;
      cnt_q  <= idx + 1'b1;
    end else if (held_q && m_ready) begin
      if (final_copy) begin
        held_q <= 1'b0;
      end else begin
        rep_q <= rep_q + 2'd1;
        sol_q <= 1'b0;
      end
    end
  end

  assign m_valid = held_q;
  assign m_data  = pix_q;
  assign m_sol   = sol_q;
  assign m_last  = last_q && final_copy;
endmodule

// File: rtl/hzx_interp.sv
module hzx_interp #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [3:0]    num,
  input  logic [3:0]    den,
  input  logic          smooth,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [DW-1:0] s_data,
  input  logic          s_sol,
  input  logic          s_last,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          out_sol
);
  localparam int MW = DW + 5;

  logic [DW-1:0] a_q, b_q;
  logic          a_last_q, b_last_q;
  logic          have_a_q, have_b_q;
  logic [3:0]    acc_q;
  logic          sol_pend_q;

  logic [DW-1:0] b_eff;
  logic          emit, adv, shift_ok, take;
  logic [4:0]    acc_sum;
  logic [3:0]    wa;
  logic [MW-1:0] mix, quo;
  logic [DW-1:0] near, pix;

  assign b_eff    = a_last_q ? a_q : b_q;
  assign emit     = have_a_q && (have_b_q || a_last_q);
  assign acc_sum  = {1'b0, acc_q} + {1'b0, den};
  assign adv      = (acc_sum >= {1'b0, num});
  assign shift_ok = emit && adv && !a_last_q;
  assign s_ready  = !have_a_q ||
                    (!a_last_q && (!have_b_q || (shift_ok && !b_last_q)));
  assign take     = s_valid && s_ready;

  always_comb begin
    wa  = num - acc_q;
    mix = MW'(a_q) * MW'(wa) + MW'(b_eff) * MW'(acc_q);
    case (num)
      4'd9:    quo = (mix + MW'(4)) / MW'(9);
      4'd3:    quo = (mix + MW'(1)) / MW'(3);
      default: quo = mix;
    endcase
    near = (({1'b0, acc_q} << 1) > {1'b0, num}) ? b_eff : a_q;
    pix  = smooth ? quo[DW-1:0] : near;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q        <= '0;
      b_q        <= '0;
      a_last_q   <= 1'b0;
      b_last_q   <= 1'b0;
      have_a_q   <= 1'b0;
      have_b_q   <= 1'b0;
      acc_q      <= 4'd0;
      sol_pend_q <= 1'b0;
      out_valid  <= 1'b0;
      out_data   <= '0;
      out_sol    <= 1'b0;
    end else begin
      out_valid <= emit;
      out_sol   <= emit && sol_pend_q;
      if (emit) begin
        out_data   <= pix;
        sol_pend_q <= 1'b0;
        acc_q      <= adv ? 4'(acc_sum - {1'b0, num}) : acc_sum[3:0];
      end
      if (emit && adv && a_last_q) begin
        have_a_q <= 1'b0;
        have_b_q <= 1'b0;
      end else if (shift_ok) begin
        a_q      <= b_q;
        a_last_q <= b_last_q;
        have_b_q <= take;
        if (take) begin
          b_q      <= s_data;
          b_last_q <= s_last;
        end
      end else if (take) begin
        if (!have_a_q) begin
          a_q      <= s_data;
          a_last_q <= s_last;
          have_a_q <= 1'b1;
          if (s_sol) begin
            acc_q      <= 4'd0;
            sol_pend_q <= 1'b1;
          end
        end else begin
          b_q      <= s_data;
          b_last_q <= s_last;
          have_b_q <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/hwin_hscaler.sv
module hwin_hscaler #(
  parameter int DW           = 8,
  parameter int LEN_W        = 12,
  parameter int MAX_SMOOTH_W = 720
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       zoom_mode,
  input  logic [1:0]       exp_mode,
  input  logic             win_exp_en,
  input  logic             all_exp_en,
  input  logic             smooth_en,
  input  logic [LEN_W-1:0] line_len,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [DW-1:0]    in_data,
  input  logic             in_sol,
  output logic             out_valid,
  output logic [DW-1:0]    out_data,
  output logic             out_sol
);
  logic [1:0]    zoom_q;
  logic [3:0]    num_q, den_q;
  logic          smooth_q;
  logic          z_valid, z_ready, z_sol, z_last;
  logic [DW-1:0] z_data;

  hzx_mode #(.LEN_W(LEN_W), .MAX_SMOOTH_W(MAX_SMOOTH_W)) u_mode (
    .clk(clk), .rst(rst), .zoom_mode(zoom_mode), .exp_mode(exp_mode),
    .win_exp_en(win_exp_en), .all_exp_en(all_exp_en), .smooth_en(smooth_en),
    .line_len(line_len), .zoom_q(zoom_q), .num_q(num_q), .den_q(den_q),
    .smooth_q(smooth_q)
  );

  hzx_replicate #(.DW(DW), .LEN_W(LEN_W)) u_rep (
    .clk(clk), .rst(rst), .zoom(zoom_q), .line_len(line_len),
    .s_valid(in_valid), .s_ready(in_ready), .s_data(in_data), .s_sol(in_sol),
    .m_valid(z_valid), .m_ready(z_ready), .m_data(z_data), .m_sol(z_sol),
    .m_last(z_last)
  );

  hzx_interp #(.DW(DW)) u_interp (
    .clk(clk), .rst(rst), .num(num_q), .den(den_q), .smooth(smooth_q),
    .s_valid(z_valid), .s_ready(z_ready), .s_data(z_data), .s_sol(z_sol),
    .s_last(z_last), .out_valid(out_valid), .out_data(out_data),
    .out_sol(out_sol)
  );
endmodule

// File: rtl/hwin_hscaler_chk.sv
module hwin_hscaler_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] zoom_mode,
  input logic       in_valid,
  input logic       in_ready,
  input logic       out_valid,
  input logic       out_sol
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && in_ready));

  // R2
  x2_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (zoom_mode == 2'd1 && in_valid && in_ready) |=> !in_ready);

  // R3
  x4_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (zoom_mode == 2'd2 && in_valid && in_ready) |=> !in_ready ##1 !in_ready ##1 !in_ready);

  // R11
  sol_valid_chk: assert property (@(posedge clk) disable iff (rst)
    out_sol |-> out_valid);

  // R11
  sol_gap_chk: assert property (@(posedge clk) disable iff (rst)
    out_sol |=> !out_sol);
endmodule

bind hwin_hscaler hwin_hscaler_chk u_chk (
  .clk(clk), .rst(rst), .zoom_mode(zoom_mode), .in_valid(in_valid),
  .in_ready(in_ready), .out_valid(out_valid), .out_sol(out_sol)
);

// File: tb/hwin_hscaler_tb.sv
`timescale 1ns/1ps
module hwin_hscaler_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  zoom_mode = 2'd0;
  logic [1:0]  exp_mode = 2'd0;
  logic        win_exp_en = 1'b0;
  logic        all_exp_en = 1'b0;
  logic        smooth_en = 1'b0;
  logic [11:0] line_len = 12'd1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_data = 8'd0;
  logic        in_sol = 1'b0;
  logic        out_valid;
  logic [7:0]  out_data;
  logic        out_sol;

  always #2 clk = ~clk;

  hwin_hscaler u_dut (
    .clk(clk), .rst(rst), .zoom_mode(zoom_mode), .exp_mode(exp_mode),
    .win_exp_en(win_exp_en), .all_exp_en(all_exp_en), .smooth_en(smooth_en),
    .line_len(line_len), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sol(in_sol), .out_valid(out_valid),
    .out_data(out_data), .out_sol(out_sol)
  );

  typedef struct packed {
    logic [11:0] len;
    logic [1:0]  zm;
    logic [1:0]  ex;
    logic        wen;
    logic        gen;
    logic        sm;
    logic [7:0]  seed;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{12'd16, 2'd0, 2'd0, 1'b0, 1'b0, 1'b1, 8'd3},
    '{12'd10, 2'd1, 2'd0, 1'b0, 1'b0, 1'b1, 8'd5},
    '{12'd7,  2'd2, 2'd0, 1'b0, 1'b0, 1'b1, 8'd7},
    '{12'd24, 2'd0, 2'd1, 1'b1, 1'b0, 1'b1, 8'd11},
    '{12'd13, 2'd0, 2'd2, 1'b1, 1'b0, 1'b1, 8'd13},
    '{12'd20, 2'd0, 2'd1, 1'b1, 1'b0, 1'b0, 8'd17},
    '{12'd12, 2'd0, 2'd2, 1'b0, 1'b1, 1'b1, 8'd19},
    '{12'd12, 2'd0, 2'd1, 1'b0, 1'b0, 1'b1, 8'd23},
    '{12'd9,  2'd1, 2'd2, 1'b1, 1'b0, 1'b1, 8'd29},
    '{12'd11, 2'd3, 2'd3, 1'b1, 1'b0, 1'b1, 8'd31}
  };

  function automatic string vtag(input int i);
    case (i)
      0: return "R4";
      1: return "R2";
      2: return "R3";
      3: return "R5";
      4: return "R6 R7";
      5: return "R8";
      6: return "R9 global";
      7: return "R9 disabled";
      8: return "R10";
      default: return "R4 R9 reserved";
    endcase
  endfunction

  int n_chk = 0;
  int n_err = 0;
  int gcnt = 0;
  int got_pix [8192];
  bit got_sol [8192];
  int exp_pix [4096];
  bit exp_sol [4096];
  int ecnt = 0;

  always @(negedge clk) begin
    if (!rst && out_valid && gcnt < 8192) begin
      got_pix[gcnt] = int'(out_data);
      got_sol[gcnt] = out_sol;
      gcnt = gcnt + 1;
    end
  end

  task automatic check(input string tag, input string what, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  function automatic int src(input int seed, input int i);
    return (seed * 37 + i * 53 + (i * i) % 17) & 255;
  endfunction

  task automatic add_line(input int len, input int zm, input int ex, input bit wen,
                          input bit gen, input bit sm, input int seed);
    int z, n, m, lz, cnt;
    bit filt;
    z = (zm == 1) ? 2 : (zm == 2) ? 4 : 1;
    n = 1; m = 1;
    if (wen || gen) begin
      if (ex == 1) begin n = 9; m = 8; end
      else if (ex == 2) begin n = 3; m = 2; end
    end
    lz   = len * z;
    cnt  = (lz * n + m - 1) / m;
    filt = sm && (cnt <= 720);
    for (int k = 0; k < cnt; k++) begin
      int pos, i, f, a, b;
      pos = k * m;
      i = pos / n;
      f = pos % n;
      a = src(seed, i / z);
      b = (i + 1 < lz) ? src(seed, (i + 1) / z) : a;
      exp_pix[ecnt] = filt ? (a * (n - f) + b * f + n / 2) / n : ((2 * f > n) ? b : a);
      exp_sol[ecnt] = (k == 0);
      ecnt++;
    end
  endtask

  task automatic configure(input vec_t v);
    @(negedge clk);
    rst = 1'b1;
    zoom_mode = v.zm; exp_mode = v.ex; win_exp_en = v.wen;
    all_exp_en = v.gen; smooth_en = v.sm; line_len = v.len;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    ecnt = 0;
  endtask

  task automatic send_line(input int len, input int seed);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = 8'(src(seed, i));
      in_sol   = (i == 0);
      #1;
      while (!in_ready) begin
        @(negedge clk);
        #1;
      end
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_sol   = 1'b0;
  endtask

  task automatic collect_and_compare(input string tag, input int start);
    int t;
    t = 0;
    while (gcnt - start < ecnt && t < 20000) begin
      @(negedge clk);
      t++;
    end
    repeat (20) @(negedge clk);
    check(tag, "output count", gcnt - start, ecnt);
    for (int k = 0; k < ecnt; k++) begin
      check(tag, $sformatf("pixel %0d", k), got_pix[start + k], exp_pix[k]);
      check(tag, $sformatf("line start flag %0d (R11)", k), int'(got_sol[start + k]), int'(exp_sol[k]));
    end
  endtask

  task automatic run_vec(input string tag, input vec_t v);
    int start;
    configure(v);
    add_line(v.len, v.zm, v.ex, v.wen, v.gen, v.sm, v.seed);
    start = gcnt;
    send_line(v.len, v.seed);
    collect_and_compare(tag, start);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    finish_run();
  end

  initial begin
    vec_t v;
    int start;
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1", "out_valid in reset", int'(out_valid), 0);
    check("R1", "in_ready in reset", int'(in_ready), 1);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "out_valid after reset", int'(out_valid), 0);
    check("R1", "in_ready after reset", int'(in_ready), 1);

    for (int i = 0; i < NV; i++) run_vec(vtag(i), VECS[i]);

    // R2: zoom x2 stalls input for the cycle after an accept
    v = '{12'd4, 2'd1, 2'd0, 1'b0, 1'b0, 1'b1, 8'd41};
    configure(v);
    @(negedge clk);
    in_valid = 1'b1; in_data = 8'd9; in_sol = 1'b1;
    #1;
    check("R2", "in_ready before accept", int'(in_ready), 1);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0; in_sol = 1'b0;
    #1;
    check("R2", "in_ready after accept", int'(in_ready), 0);

    // R12: 640 at 9/8 gives exactly 720 and stays smoothed
    run_vec("R12 width 720", '{12'd640, 2'd0, 2'd1, 1'b1, 1'b0, 1'b1, 8'd43});
    // R8 R12: 320 x2 at 3/2 gives 960, beyond the limit, nearest pick
    run_vec("R8 R12 width 960", '{12'd320, 2'd1, 2'd2, 1'b1, 1'b0, 1'b1, 8'd47});

    // R11: two 9/8 lines back to back, phase nonzero at end of the first
    v = '{12'd5, 2'd0, 2'd1, 1'b1, 1'b0, 1'b1, 8'd53};
    configure(v);
    add_line(5, 0, 1, 1'b1, 1'b0, 1'b1, 53);
    add_line(5, 0, 1, 1'b1, 1'b0, 1'b1, 59);
    start = gcnt;
    send_line(5, 53);
    send_line(5, 59);
    collect_and_compare("R11 phase restart", start);

    finish_run();
  end
endmodule